// File: doc/BRIEF.md
# Bit-Oriented Code Transceiver

This block carries 6-bit bit-oriented codes over the serial data-link bit stream of a framed line, such as the facility data link in T1 extended-superframe overhead. The host writes a code and an enable. While enabled, the transmitter repeats a 16-bit pattern made of eight ones, a zero, the six code bits with the least significant bit first, and a closing zero. When disabled, it sends idle ones. Serial bits move only on cycles where the bit-enable strobe is high.

The receiver looks for the same pattern in the incoming bits and locks onto its 16-bit phase. It accepts a code after three identical patterns in a row and holds that value for the host. It raises one event when a code is accepted and another when the accepted code stops arriving. A small register port gives access to the transmit control, the latched events, an interrupt mask and the received code. Reading the event register clears it.

Top module: `boc_xcvr`

## Requirements
- R1: Register 0 holds the transmit code in bits [5:0] and the transmit enable in bit 6. A write to it reads back the same value in bits [6:0], with bit 7 reading zero.
- R2: While transmission is active, `tx_bit` repeats this 16-bit pattern: bits 0 to 7 are one, bit 8 is zero, bits 9 to 14 are code bits 0 to 5, and bit 15 is zero.
- R3: A change of the enable or code takes effect only after bit 15 of the current pattern has been sent. While inactive, `tx_bit` is 1.
- R4: The transmit position and the receive bit history advance only on cycles where `bit_en` is high. `tx_bit` holds its value on every other cycle.
- R5: The receiver accepts a code after three consecutive pattern-aligned valid patterns carry the same code. It then sets event bit 0 of register 1, shows the code in bits [5:0] of register 3, and sets bit 7 of register 3 (code present). Two such patterns are not enough.
- R6: While a code is present, two consecutive 16-bit windows that do not carry the held code set event bit 1 of register 1 and clear the present bit. The held code value is kept.
- R7: Register 2 bits [1:0] mask event bits [1:0]. `irq` is high exactly when an event bit is set and its mask bit is one.
- R8: A read of register 1 (`rd_en` with `addr` = 1) clears both event bits at the next clock edge. An event raised at that same edge stays set.
- R9: Valid patterns that repeat the code already present raise no new detect event.
- R10: After reset, all registers read zero, `tx_bit` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Data-link bit strobe, one serial bit per high cycle |
| rx_bit | input | 1 | Received data-link bit, sampled when `bit_en` is high |
| tx_bit | output | 1 | Transmitted data-link bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears events when addr is 1) |
| addr | input | 2 | Register select: 0 transmit control, 1 events, 2 mask, 3 received code |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for the selected register |
| irq | output | 1 | Interrupt, any unmasked event |

## Verification
The checker watches these rules on every cycle:
- `tx_bit` does not move without a strobe.
- The output is one whenever transmission is inactive.
- An event-register read with no strobe leaves the events at zero.
- A detect event is only raised together with code present.
- A cease event is only raised together with code not present.
- The held code changes only on a detect.
- A zero mask silences the interrupt.

The bench scenarios are needed for the rest. They show the exact pattern bit order through loopback, the boundary-only effect of enable changes, and the three-pattern acceptance threshold against a two-pattern burst. They also show that the code is not reported again while it repeats, and the two-window cease timing under a slow strobe.

// File: rtl/boc_pkg.sv
package boc_pkg;
  localparam int CODE_W_D   = 6;
  localparam int PRE_ONES_D = 8;
  localparam int DET_CNT_D  = 3;
  localparam int CEASE_CNT_D = 2;
  localparam int DATA_W_D   = 8;

  typedef enum logic [1:0] {
    REG_TXCTL  = 2'd0,
    REG_EVENT  = 2'd1,
    REG_MASK   = 2'd2,
    REG_RXCODE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/boc_tx.sv
module boc_tx import boc_pkg::*; #(
  parameter int CODE_W   = CODE_W_D,
  parameter int PRE_ONES = PRE_ONES_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              ctl_en,
  input  logic [CODE_W-1:0] ctl_code,
  output logic              tx_bit,
  output logic              active
);
  localparam int PAT_LEN = PRE_ONES + CODE_W + 2;
  localparam int POS_W   = $clog2(PAT_LEN);
  localparam logic [POS_W-1:0] LAST = POS_W'(PAT_LEN - 1);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic              act_q, act_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              pat_bit;

  always_comb begin
    pos_d  = pos_q;
    act_d  = act_q;
    code_d = code_q;
    if (bit_en) begin
      if (pos_q == LAST) begin
        pos_d  = '0;
        act_d  = ctl_en;
        code_d = ctl_code;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      act_q  <= 1'b0;
      code_q <= '0;
    end else begin
      pos_q  <= pos_d;
      act_q  <= act_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    pat_bit = (pos_q < POS_W'(PRE_ONES));
    for (int i = 0; i < CODE_W; i++) begin
      if (pos_q == POS_W'(PRE_ONES + 1 + i)) pat_bit = code_q[i];
    end
  end

  assign tx_bit = !act_q || pat_bit;
  assign active = act_q;
endmodule

// File: rtl/boc_rx.sv
module boc_rx import boc_pkg::*; #(
  parameter int CODE_W    = CODE_W_D,
  parameter int PRE_ONES  = PRE_ONES_D,
  parameter int DET_CNT   = DET_CNT_D,
  parameter int CEASE_CNT = CEASE_CNT_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  output logic              det_pulse,
  output logic              cease_pulse,
  output logic [CODE_W-1:0] held_code,
  output logic              present
);
  localparam int PAT_LEN = PRE_ONES + CODE_W + 2;
  localparam int POS_W   = $clog2(PAT_LEN);
  localparam int RUN_W   = $clog2(DET_CNT + 1);
  localparam int MISS_W  = $clog2(CEASE_CNT + 1);
  localparam logic [POS_W-1:0] LAST = POS_W'(PAT_LEN - 1);

  logic [PAT_LEN-1:0] sh_q, sh_d, sh_n;
  logic [POS_W-1:0]   wcnt_q, wcnt_d;
  logic               al_q, al_d;
  logic [CODE_W-1:0]  cand_q, cand_d, held_q, held_d, rcv_code;
  logic [RUN_W-1:0]   run_q, run_d;
  logic [MISS_W-1:0]  miss_q, miss_d;
  logic               pres_q, pres_d;
  logic               match, eval;

  assign sh_n     = {rx_bit, sh_q[PAT_LEN-1:1]};
  assign rcv_code = sh_n[PRE_ONES+CODE_W:PRE_ONES+1];
  assign match    = (&sh_n[PRE_ONES-1:0]) && !sh_n[PRE_ONES] && !sh_n[PAT_LEN-1];
  assign eval     = bit_en && ((wcnt_q == LAST) || (!al_q && match));

  always_comb begin
    sh_d = sh_q;  wcnt_d = wcnt_q;  al_d = al_q;  cand_d = cand_q;
    run_d = run_q;  miss_d = miss_q;  held_d = held_q;  pres_d = pres_q;
    det_pulse = 1'b0;
    cease_pulse = 1'b0;
    if (bit_en) begin
      sh_d   = sh_n;
      wcnt_d = (wcnt_q == LAST) ? '0 : wcnt_q + 1'b1;
    end
    if (eval) begin
      wcnt_d = '0;
      if (match) begin
        al_d = 1'b1;
        if (run_q != '0 && cand_q == rcv_code) begin
          if (run_q != RUN_W'(DET_CNT)) run_d = run_q + 1'b1;
        end else begin
          cand_d = rcv_code;
          run_d  = RUN_W'(1);
        end
      end else begin
        al_d  = 1'b0;
        run_d = '0;
      end
      if (pres_q) begin
        if (match && rcv_code == held_q) begin
          miss_d = '0;
        end else if (miss_q == MISS_W'(CEASE_CNT - 1)) begin
          pres_d = 1'b0;
          miss_d = '0;
          cease_pulse = 1'b1;
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
      if (match && run_d == RUN_W'(DET_CNT) && !(pres_q && held_q == rcv_code)) begin
        held_d = rcv_code;
        pres_d = 1'b1;
        miss_d = '0;
        det_pulse = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;  wcnt_q <= '0;  al_q <= 1'b0;  cand_q <= '0;
      run_q <= '0; miss_q <= '0;  held_q <= '0; pres_q <= 1'b0;
    end else begin
      sh_q <= sh_d;  wcnt_q <= wcnt_d;  al_q <= al_d;  cand_q <= cand_d;
      run_q <= run_d; miss_q <= miss_d;  held_q <= held_d; pres_q <= pres_d;
    end
  end

  assign held_code = held_q;
  assign present   = pres_q;
endmodule

// File: rtl/boc_regs.sv
module boc_regs import boc_pkg::*; #(
  parameter int CODE_W = CODE_W_D,
  parameter int DATA_W = DATA_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              det_pulse,
  input  logic              cease_pulse,
  input  logic [CODE_W-1:0] held_code,
  input  logic              present,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              ctl_en,
  output logic [CODE_W-1:0] ctl_code,
  output logic [1:0]        evt,
  output logic [1:0]        mask
);
  logic [CODE_W:0] ctl_q, ctl_d;
  logic [1:0]      evt_q, evt_d, mask_q, mask_d;
  reg_addr_e       sel;

  assign sel = reg_addr_e'(addr);

  always_comb begin
    ctl_d  = ctl_q;
    mask_d = mask_q;
    evt_d  = evt_q;
    if (wr_en && sel == REG_TXCTL) ctl_d  = wdata[CODE_W:0];
    if (wr_en && sel == REG_MASK)  mask_d = wdata[1:0];
    if (rd_en && sel == REG_EVENT) evt_d  = '0;
    evt_d = evt_d | {cease_pulse, det_pulse};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mask_q <= '0;
      evt_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      mask_q <= mask_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      REG_TXCTL:  rdata[CODE_W:0] = ctl_q;
      REG_EVENT:  rdata[1:0] = evt_q;
      REG_MASK:   rdata[1:0] = mask_q;
      REG_RXCODE: begin
        rdata[CODE_W-1:0] = held_code;
        rdata[DATA_W-1]   = present;
      end
      default:    rdata = '0;
    endcase
  end

  assign irq      = |(evt_q & mask_q);
  assign ctl_en   = ctl_q[CODE_W];
  assign ctl_code = ctl_q[CODE_W-1:0];
  assign evt      = evt_q;
  assign mask     = mask_q;
endmodule

// File: rtl/boc_xcvr.sv
module boc_xcvr import boc_pkg::*; #(
  parameter int CODE_W    = CODE_W_D,
  parameter int PRE_ONES  = PRE_ONES_D,
  parameter int DET_CNT   = DET_CNT_D,
  parameter int CEASE_CNT = CEASE_CNT_D,
  parameter int DATA_W    = DATA_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  output logic              tx_bit,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [1:0]        rs_q;
  logic              srst_n;
  logic              ctl_en, tx_active, det_pulse, cease_pulse, present;
  logic [CODE_W-1:0] ctl_code, held_code;
  logic [1:0]        evt, mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  boc_tx #(.CODE_W(CODE_W), .PRE_ONES(PRE_ONES)) u_tx (
    .clk(clk), .rst_n(srst_n), .bit_en(bit_en), .ctl_en(ctl_en),
    .ctl_code(ctl_code), .tx_bit(tx_bit), .active(tx_active)
  );

  boc_rx #(.CODE_W(CODE_W), .PRE_ONES(PRE_ONES), .DET_CNT(DET_CNT),
           .CEASE_CNT(CEASE_CNT)) u_rx (
    .clk(clk), .rst_n(srst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .det_pulse(det_pulse), .cease_pulse(cease_pulse),
    .held_code(held_code), .present(present)
  );

  boc_regs #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .det_pulse(det_pulse), .cease_pulse(cease_pulse),
    .held_code(held_code), .present(present), .rdata(rdata), .irq(irq),
    .ctl_en(ctl_en), .ctl_code(ctl_code), .evt(evt), .mask(mask)
  );
endmodule

// File: rtl/boc_xcvr_chk.sv
module boc_xcvr_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bit_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic              tx_bit,
  input logic              tx_active,
  input logic [1:0]        evt,
  input logic [1:0]        mask,
  input logic              present,
  input logic [CODE_W-1:0] held_code,
  input logic              det_pulse,
  input logic              irq
);
  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !bit_en |=> $stable(tx_bit));
  // R3
  idle_one_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !tx_active |-> tx_bit);
  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && addr == 2'd1 && !bit_en) |=> (evt == 2'b00));
  // R5
  det_sets_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(evt[0]) |-> present);
  // R6
  cease_clr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(evt[1]) |-> !present);
  // R6
  code_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !det_pulse |=> $stable(held_code));
  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mask == 2'b00) |-> !irq);
endmodule

bind boc_xcvr boc_xcvr_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .bit_en(bit_en), .rd_en(rd_en), .addr(addr),
  .tx_bit(tx_bit), .tx_active(tx_active), .evt(evt), .mask(mask),
  .present(present), .held_code(held_code), .det_pulse(det_pulse), .irq(irq)
);

// File: tb/sim_boc_xcvr.sv
`timescale 1ns/1ps
module sim_boc_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, rx_bit = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       tx_bit, irq;
  logic [7:0] rdata;

  int n_chk = 0, n_bad = 0;
  int en_div = 1, divc = 0;
  bit run = 0, loop = 0, have_prev = 0, prev_en = 0, prev_tx = 1;
  bit rxq[$];

  // behavioural reference state
  int m_pos, m_act, m_code, m_ctl, m_mask, m_stat, m_w, m_al;
  int m_cand, m_run, m_miss, m_held, m_pres;
  bit hist[$];

  boc_xcvr u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .tx_bit(tx_bit), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  function automatic int pat(int p, int c);
    if (p < 8) return 1;
    if (p == 8 || p == 15) return 0;
    return (c >> (p - 9)) & 1;
  endfunction

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int ev_d, ev_c, valid, rc, evl;
    if (!rst_n) begin
      m_pos = 0; m_act = 0; m_code = 0; m_ctl = 0; m_mask = 0; m_stat = 0;
      m_w = 0; m_al = 0; m_cand = 0; m_run = 0; m_miss = 0; m_held = 0; m_pres = 0;
      hist.delete();
    end else begin
      ev_d = 0; ev_c = 0;
      if (bit_en) begin
        if (m_pos == 15) begin
          m_pos = 0; m_act = (m_ctl >> 6) & 1; m_code = m_ctl & 63;
        end else m_pos++;
        hist.push_back(rx_bit);
        if (hist.size() > 16) void'(hist.pop_front());
        valid = (hist.size() == 16);
        rc = 0;
        if (valid) begin
          for (int i = 0; i < 8; i++) if (!hist[i]) valid = 0;
          if (hist[8] || hist[15]) valid = 0;
          for (int i = 0; i < 6; i++) rc |= int'(hist[9+i]) << i;
        end
        evl = (m_w == 15) || (!m_al && valid);
        m_w = (m_w + 1) % 16;
        if (evl) begin
          m_w = 0;
          if (valid) begin
            m_al = 1;
            if (m_run > 0 && m_cand == rc) begin
              if (m_run < 3) m_run++;
            end else begin
              m_cand = rc; m_run = 1;
            end
          end else begin
            m_al = 0; m_run = 0;
          end
          if (m_pres) begin
            if (valid && rc == m_held) m_miss = 0;
            else if (m_miss == 1) begin m_pres = 0; m_miss = 0; ev_c = 1; end
            else m_miss++;
          end
          if (valid && m_run == 3 && !(m_pres && m_held == rc)) begin
            m_held = rc; m_pres = 1; m_miss = 0; ev_d = 1;
          end
        end
      end
      if (rd_en && addr == 2'd1) m_stat = 0;
      m_stat |= ev_d | (ev_c << 1);
      if (wr_en && addr == 2'd0) m_ctl = wdata & 8'h7f;
      if (wr_en && addr == 2'd2) m_mask = wdata & 3;
    end
  end

  // strobe and serial driver
  always @(negedge clk) begin
    if (!run) bit_en = 0;
    else begin
      divc++;
      if (divc >= en_div) begin
        divc = 0; bit_en = 1;
        if (loop) rx_bit = tx_bit;
        else if (rxq.size() > 0) rx_bit = rxq.pop_front();
        else rx_bit = 1;
      end else bit_en = 0;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    int e_rd;
    #3;
    if (rst_n) begin
      chk(tx_bit, (!m_act) ? 1 : pat(m_pos, m_code), "R2 R3 tx_bit");
      chk(irq, ((m_stat & m_mask) != 0), "R7 irq");
      case (addr)
        2'd0: e_rd = m_ctl;
        2'd1: e_rd = m_stat;
        2'd2: e_rd = m_mask;
        default: e_rd = (m_pres << 7) | m_held;
      endcase
      chk(rdata, e_rd, "R1 rdata");
      if (have_prev && !prev_en) chk(tx_bit, prev_tx, "R4 hold");
      have_prev = 1;
    end
    prev_tx = tx_bit; prev_en = bit_en;
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = a[1:0]; wdata = d[7:0];
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); rd_en = 1; addr = a[1:0];
    #4 v = rdata;
    @(negedge clk); rd_en = 0; addr = 0;
  endtask

  task automatic push_pat(int c);
    for (int p = 0; p < 16; p++) rxq.push_back(pat(p, c) != 0);
  endtask

  task automatic drain();
    while (rxq.size() > 0) @(negedge clk);
    repeat (3 * en_div) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R10 reset state
    for (int a = 0; a < 4; a++) begin rd(a, v); chk(v, 0, "R10 reg"); end
    chk(tx_bit, 1, "R10 tx_bit");
    chk(irq, 0, "R10 irq");
    run = 1;
    // R1 write and read back
    wr(0, 8'h6D);
    rd(0, v); chk(v, 8'h6D, "R1 readback");
    // R2 loopback: the transmit pattern decodes to the written code
    loop = 1;
    repeat (96) @(negedge clk);
    rd(3, v); chk(v, 8'hAD, "R2 R5 rxcode");
    rd(1, v); chk(v, 1, "R5 det event");
    rd(1, v); chk(v, 0, "R8 cleared");
    // R9 repeated code raises nothing new
    repeat (80) @(negedge clk);
    rd(1, v); chk(v, 0, "R9 no re-detect");
    // R3 disable ends at a boundary, then idle ones; R6 cease follows
    wr(0, 8'h2D);
    repeat (17) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); #3 chk(tx_bit, 1, "R3 idle");
    end
    repeat (40) @(negedge clk);
    rd(1, v); chk(v, 2, "R6 cease event");
    rd(3, v); chk(v, 8'h2D, "R6 code kept");
    // R7 masked detect interrupt under a slow strobe
    loop = 0; en_div = 3;
    wr(2, 1);
    rxq.push_back(1); rxq.push_back(0); rxq.push_back(1); rxq.push_back(1);
    rxq.push_back(0); rxq.push_back(0); rxq.push_back(1);
    for (int k = 0; k < 4; k++) push_pat(6'h15);
    drain();
    chk(irq, 1, "R7 irq detect");
    rd(3, v); chk(v, 8'h95, "R5 rxcode slow");
    rd(1, v); chk(v, 1, "R5 det slow");
    @(negedge clk); #3 chk(irq, 0, "R7 irq after read");
    repeat (150) @(negedge clk);
    chk(irq, 0, "R7 cease masked");
    wr(2, 2);
    #3 chk(irq, 1, "R7 cease unmasked");
    rd(1, v); chk(v, 2, "R6 cease slow");
    rd(3, v); chk(v, 8'h15, "R6 held slow");
    // R5 two patterns do not make a detect
    push_pat(6'h3F); push_pat(6'h3F);
    drain();
    repeat (150) @(negedge clk);
    rd(1, v); chk(v, 0, "R5 two not enough");
    rd(3, v); chk(v, 8'h15, "R5 code unchanged");
    // R4 strobe gating with transmit running at a slow strobe
    wr(0, 8'h40 | 8'h0B);
    repeat (200) @(negedge clk);
    run = 0;
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule